// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a small bit-level bus master for a two-wire (I2C) bus. Its job starts right after a byte load to a nonvolatile target has ended with STOP. At that point the target is busy with its internal write and ignores its address. The poller then sends START followed by an address byte, again and again, and looks at the acknowledge bit on the ninth clock. A NACK means the target is still busy, so the poller closes that attempt with STOP and begins a fresh one straight away. The first ACK means the write has finished. The poller signals ready and then does one of two things. It may close the bus with STOP. It may instead keep the bus, with no STOP, so that the caller's next read or write command follows on from the addressed target.

An attempt limit bounds the wait. When that many attempts have all been NACKed, the poller raises a timeout, issues STOP and leaves the bus idle. Both bus lines are driven open-drain: an output of 1 pulls the line low, and an output of 0 lets it float high. The bit rate is set by a parameter that gives the length of each SCL half period in system clocks.

Top module: `ackpoll_master`

## Requirements
- R1: After reset, both line drives are released (`scl_lo`=0, `sda_lo`=0) and `ready`, `timeout` and `busy` are 0.
- R2: Each attempt is a START (SDA falls while SCL is high) followed by eight data bits sent MSB first. Bits 7..1 carry `tgt_addr[6:0]` and bit 0 carries `rd_sel` (1 = read, 0 = write). The address and direction are captured when `poll_go` is accepted.
- R3: Apart from the START and STOP edges, SDA changes only while SCL is low.
- R4: If SDA is high on the ninth clock (NACK) and the attempt limit has not been reached, the poller issues STOP (SDA rises while SCL is high) and then at once issues a new START with the same byte.
- R5: If SDA is low on the ninth clock (ACK), `ready` is high for exactly one clock cycle, and no further attempt is made.
- R6: On ACK with `cont_req`=0, the poller issues one STOP, leaves both lines released and drops `busy`.
- R7: On ACK with `cont_req`=1, no STOP is issued. SCL is held low and SDA is released for as long as `cont_req` stays high. Once `cont_req` falls, one STOP follows and `busy` drops.
- R8: When MAX_TRIES attempts in a row have been NACKed, `timeout` is high for one cycle, a STOP is issued, `busy` drops and no further START follows.
- R9: Within a bit, SCL stays high for exactly HALF_CLKS system clocks.
- R10: A `poll_go` pulse that arrives while `busy` is high is ignored. The byte being sent and the number of attempts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_go | input | 1 | Start a polling run (accepted only when idle) |
| tgt_addr | input | 7 | Target address to poll |
| rd_sel | input | 1 | Direction bit of the address byte (1 = read) |
| cont_req | input | 1 | On ACK, keep the bus for a following command instead of STOP |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_lo | output | 1 | Pull SCL low when 1 |
| sda_lo | output | 1 | Pull SDA low when 1 |
| ready | output | 1 | One-cycle pulse: target acknowledged |
| timeout | output | 1 | One-cycle pulse: attempt limit reached |
| busy | output | 1 | Poller owns the bus |

## Verification
The bench builds the poller with HALF_CLKS=3 and MAX_TRIES=4. Short bit cells keep each attempt to a few dozen clocks. With a limit of four, a target model that stays busy for 0 to 5 attempts reaches every outcome: an ACK on the first attempt, an ACK on the very last allowed attempt, and a timeout. Random cases vary the address, the direction and the continue choice. Directed cases cover an early ACK, an ACK on the last allowed attempt, a timeout, and a `poll_go` pulse that arrives during a run.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_START,
    PS_BLO,
    PS_BHI,
    PS_HOLD,
    PS_SLO,
    PS_SHI,
    PS_SREL
  } poll_st_e;

  localparam int FRAME_BITS = 9;

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  // value placed on SDA for bit idx; the ninth bit is left released (1)
  function automatic logic frame_bit(input logic [7:0] b, input logic [3:0] idx);
    logic v;
    v = 1'b1;
    for (int k = 0; k < 8; k++)
      if (idx == 4'(k)) v = b[7-k];
    return v;
  endfunction

endpackage

// File: rtl/ackpoll_phase_timer.sv
module ackpoll_phase_timer #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(HALF_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R9
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && !$past(tick)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  initial begin
    min_half_chk: assert (HALF_CLKS >= 2);
  end
endmodule

// File: rtl/ackpoll_retry.sv
module ackpoll_retry #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic nack_evt,
  output logic last_try
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST = TRY_W'(MAX_TRIES - 1);

  logic [TRY_W-1:0] tries_q;

  assign last_try = (tries_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tries_q <= '0;
    else if (clear)    tries_q <= '0;
    else if (nack_evt && !last_try) tries_q <= tries_q + 1'b1;
  end

  // R8
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= LAST);

  // R8
  no_nack_after_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nack_evt) && $past(last_try) && !clear) |-> last_try);
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic [6:0] addr,
  input  logic       rd,
  input  logic       cont,
  input  logic       sda_in,
  input  logic       last_try,
  output logic       run,
  output logic       clear_tries,
  output logic       nack_evt,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic       ready,
  output logic       timeout,
  output logic       busy
);
  poll_st_e   st_q, st_d;
  logic [7:0] byte_q;
  logic [3:0] bit_q, bit_d;
  logic       again_q, again_d;
  logic       scl_q, sda_q, rdy_q, to_q;
  logic       scl_want, sda_want, sda_may_move;

  // named internal events
  logic accept_go, ninth_end, ack_seen, nack_seen;

  assign accept_go = (st_q == PS_IDLE) && go;
  assign ninth_end = tick && (st_q == PS_BHI) && (bit_q == 4'(FRAME_BITS - 1));
  assign ack_seen  = ninth_end && !sda_in;
  assign nack_seen = ninth_end && sda_in;

  assign run         = (st_q != PS_IDLE);
  assign clear_tries = accept_go;
  assign nack_evt    = nack_seen;
  assign busy        = run;

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    again_d = again_q;
    unique case (st_q)
      PS_IDLE:  if (go) st_d = PS_START;
      PS_START: if (tick) begin st_d = PS_BLO; bit_d = '0; end
      PS_BLO:   if (tick) st_d = PS_BHI;
      PS_BHI:   if (tick) begin
        if (ack_seen) begin
          st_d    = cont ? PS_HOLD : PS_SLO;
          again_d = 1'b0;
        end else if (nack_seen) begin
          st_d    = PS_SLO;
          again_d = !last_try;
        end else begin
          st_d  = PS_BLO;
          bit_d = bit_q + 1'b1;
        end
      end
      PS_HOLD:  if (tick && !cont) st_d = PS_SLO;
      PS_SLO:   if (tick) st_d = PS_SHI;
      PS_SHI:   if (tick) st_d = PS_SREL;
      PS_SREL:  if (tick) st_d = again_q ? PS_START : PS_IDLE;
      default:  st_d = PS_IDLE;
    endcase
  end

  always_comb begin
    scl_want = (st_q == PS_BLO) || (st_q == PS_HOLD) || (st_q == PS_SLO);
    unique case (st_q)
      PS_START:       sda_want = 1'b1;
      PS_BLO, PS_BHI: sda_want = !frame_bit(byte_q, bit_q);
      PS_SLO, PS_SHI: sda_want = 1'b1;
      default:        sda_want = 1'b0;
    endcase
    // data moves only once SCL is already low; START/STOP edges are the exceptions
    sda_may_move = scl_q || (st_q == PS_START) || (st_q == PS_SREL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      bit_q   <= '0;
      again_q <= 1'b0;
      byte_q  <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      rdy_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      again_q <= again_d;
      if (accept_go) byte_q <= addr_byte(addr, rd);
      scl_q   <= scl_want;
      if (sda_may_move) sda_q <= sda_want;
      rdy_q   <= ack_seen;
      to_q    <= nack_seen && last_try;
    end
  end

  assign scl_lo  = scl_q;
  assign sda_lo  = sda_q;
  assign ready   = rdy_q;
  assign timeout = to_q;

  // R3
  sda_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && !$past(scl_q) && (sda_q != $past(sda_q)))
      |-> ($past(st_q) == PS_START || $past(st_q) == PS_SREL));

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R8
  ready_vs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timeout));

  // R7
  hold_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HOLD && $past(st_q) == PS_HOLD) |-> (scl_lo && !sda_lo));

  // R10
  byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) != PS_IDLE) |-> $stable(byte_q));
endmodule

// File: rtl/ackpoll_master.sv
module ackpoll_master #(
  parameter int HALF_CLKS = 4,
  parameter int MAX_TRIES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       poll_go,
  input  logic [6:0] tgt_addr,
  input  logic       rd_sel,
  input  logic       cont_req,
  input  logic       sda_in,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic       ready,
  output logic       timeout,
  output logic       busy
);
  logic run, tick, clear_tries, nack_evt, last_try;

  ackpoll_phase_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  ackpoll_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(clear_tries),
    .nack_evt(nack_evt), .last_try(last_try)
  );

  ackpoll_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(poll_go),
    .addr(tgt_addr), .rd(rd_sel), .cont(cont_req), .sda_in(sda_in),
    .last_try(last_try), .run(run), .clear_tries(clear_tries),
    .nack_evt(nack_evt), .scl_lo(scl_lo), .sda_lo(sda_lo),
    .ready(ready), .timeout(timeout), .busy(busy)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!scl_lo && !sda_lo));
endmodule

// File: tb/sim_ackpoll_master.sv
module sim_ackpoll_master;
  localparam int HALF = 3;
  localparam int MAXT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_go = 1'b0, rd_sel = 1'b0, cont_req = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic scl_lo, sda_lo, ready, timeout, busy;
  logic ack_drv = 1'b0;
  logic scl_bus, sda_bus;

  assign scl_bus = !scl_lo;
  assign sda_bus = !(sda_lo || ack_drv);

  ackpoll_master #(.HALF_CLKS(HALF), .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .poll_go(poll_go), .tgt_addr(tgt_addr),
    .rd_sel(rd_sel), .cont_req(cont_req), .sda_in(sda_bus),
    .scl_lo(scl_lo), .sda_lo(sda_lo), .ready(ready), .timeout(timeout), .busy(busy)
  );

  always #4 clk = !clk;  // 125 MHz

  int compared = 0, mismatched = 0, cycles = 0;

  // target model / bus monitor
  int n_start = 0, n_stop = 0, n_att = 0, n_badbyte = 0, n_rdy = 0, n_to = 0;
  int n_widepulse = 0, n_badhigh = 0, busy_att = 0;
  logic [7:0] exp_byte = '0;
  logic p_scl = 1'b1, p_sda = 1'b1, p_rdy = 1'b0, p_to = 1'b0, in_frame = 1'b0, saw_rise = 1'b0;
  int bitcnt = 0, hi_len = 0, att_this_run = 0;
  logic [7:0] shreg = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    p_scl <= scl_bus; p_sda <= sda_bus; p_rdy <= ready; p_to <= timeout;
    if (ready) n_rdy <= n_rdy + 1;
    if (timeout) n_to <= n_to + 1;
    if ((ready && p_rdy) || (timeout && p_to)) n_widepulse <= n_widepulse + 1;
    if (scl_bus) hi_len <= hi_len + 1;
    if (p_scl && scl_bus && p_sda && !sda_bus) begin
      n_start <= n_start + 1; in_frame <= 1'b1; bitcnt <= 0; shreg <= '0; saw_rise <= 1'b0;
    end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
      n_stop <= n_stop + 1; in_frame <= 1'b0;
    end else if (in_frame && !p_scl && scl_bus) begin
      if (bitcnt < 8) shreg <= {shreg[6:0], sda_bus};
      bitcnt <= bitcnt + 1; hi_len <= 1; saw_rise <= 1'b1;
    end else if (in_frame && p_scl && !scl_bus) begin
      if (saw_rise && hi_len != HALF) n_badhigh <= n_badhigh + 1;
      if (bitcnt == 8) begin
        n_att <= n_att + 1;
        att_this_run <= att_this_run + 1;
        if (shreg != exp_byte) n_badbyte <= n_badbyte + 1;
        if (att_this_run >= busy_att) ack_drv <= 1'b1;
      end
      if (bitcnt == 9) ack_drv <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_attempts(input int b);
    return (b + 1 < MAXT) ? b + 1 : MAXT;
  endfunction

  function automatic bit exp_acks(input int b);
    return b < MAXT;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_case(input int b, input bit c, input logic [6:0] a, input bit r, input bit extra_go);
    int s0, e0, a0, r0, t0, bb0, guard;
    @(negedge clk);
    busy_att = b; cont_req = c; tgt_addr = a; rd_sel = r;
    exp_byte = {a, r}; att_this_run = 0;
    s0 = n_start; e0 = n_stop; a0 = n_att; r0 = n_rdy; t0 = n_to; bb0 = n_badbyte;
    poll_go = 1'b1; @(negedge clk); poll_go = 1'b0;
    if (extra_go) begin
      wait_cyc(10 * HALF);
      tgt_addr = ~a; rd_sel = !r; poll_go = 1'b1;
      @(negedge clk); poll_go = 1'b0;
    end
    guard = 0;
    while (n_rdy == r0 && n_to == t0 && guard < 5000) begin @(negedge clk); guard++; end
    if (c && exp_acks(b)) begin
      wait_cyc(8 * HALF);
      // R7: bus kept, no stop yet
      chk(scl_lo && !sda_lo && busy, "R7 hold lines", {scl_lo, sda_lo, busy}, 3'b101);
      chk(n_stop - e0 == exp_attempts(b) - 1, "R7 no stop while held", n_stop - e0, exp_attempts(b) - 1);
      cont_req = 1'b0;
    end
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    wait_cyc(2);
    chk((n_rdy - r0) == int'(exp_acks(b)), "R5 ready count", n_rdy - r0, int'(exp_acks(b)));
    chk((n_to - t0) == int'(!exp_acks(b)), "R8 timeout count", n_to - t0, int'(!exp_acks(b)));
    chk(n_att - a0 == exp_attempts(b), "R4 attempts", n_att - a0, exp_attempts(b));
    chk(n_start - s0 == exp_attempts(b), "R4 starts", n_start - s0, exp_attempts(b));
    chk(n_stop - e0 == exp_attempts(b), c ? "R7 stops" : "R6 stops", n_stop - e0, exp_attempts(b));
    chk(n_badbyte == bb0, extra_go ? "R10 byte kept" : "R2 address byte", n_badbyte - bb0, 0);
    chk(!scl_lo && !sda_lo && !busy, "R6 bus idle at end", {scl_lo, sda_lo, busy}, 0);
    wait_cyc(10 * HALF);
    chk(n_start - s0 == exp_attempts(b), "R8 no start after end", n_start - s0, exp_attempts(b));
  endtask

  initial begin
    void'($urandom(32'd1187));
    wait_cyc(3);
    // R1
    chk(!scl_lo && !sda_lo && !ready && !timeout && !busy, "R1 reset state",
        {scl_lo, sda_lo, ready, timeout, busy}, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(!scl_lo && !sda_lo && !busy, "R1 after reset", {scl_lo, sda_lo, busy}, 0);
    run_case(0, 1'b0, 7'h50, 1'b0, 1'b0);
    run_case(MAXT - 1, 1'b0, 7'h2b, 1'b1, 1'b0);
    run_case(MAXT, 1'b1, 7'h7f, 1'b0, 1'b0);
    run_case(2, 1'b1, 7'h01, 1'b1, 1'b0);
    run_case(1, 1'b0, 7'h33, 1'b0, 1'b1);
    for (int i = 0; i < 16; i++)
      run_case(int'($urandom % 6), bit'($urandom % 2), 7'($urandom), bit'($urandom % 2), 1'b0);
    // R3, R9 bus-level timing
    chk(n_badhigh == 0, "R9 SCL high length", n_badhigh, 0);
    chk(n_widepulse == 0, "R5 single-cycle pulses", n_widepulse, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    compared++; mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule